// File: doc/BRIEF.md
# Link Orientation and Width Training Controller

This controller brings up one port of a symmetric point-to-point chip link whose 32 pins are mirrored about a central ground line. It runs once after reset, before any normal traffic. It transmits a fixed training frame that carries its own width code. From the frames it receives, it works out whether the neighbour is mounted normally or turned 180 degrees; a turned neighbour shows up as reversed lane order. It then settles on the narrower of the two native widths and searches downward from the fastest of four clock-divider settings until a test word arrives cleanly for a whole check window.

When training ends, the controller holds the lane reversal flag, the agreed width code and the divider select. It then raises exactly one of three outcome flags: link up, training error (even the slowest divider failed), or leaf (nothing usable arrived before a timeout, so the port has no neighbour). Pad circuits and clock generation are outside the block. The rate is only a select value that the clocking logic consumes.

Top module: `link_trainer`

## Requirements
- R1: While reset is held low, and until training ends, link_up, train_err and leaf are 0. During reset, rate_sel, width_code and lane_rev are 0.
- R2: Until the rate test begins, tx_lanes carries the training frame: bits 15:0 = 0xA5C3, bits 17:16 = local_width, all other bits 0. From entry to the rate test onward, tx_lanes carries the test word 0x3C5AA5C3.
- R3: A received frame with bits 15:0 = 0xA5C3 and bits 31:18 zero means normal mounting (lane_rev = 0). A frame that has this shape after lane i is swapped with lane 31-i means rotated mounting (lane_rev = 1). From then on, every received word is read through that lane swap.
- R4: Width codes 0, 1, 2 and 3 mean 4, 8, 16 and 32 data bits. The agreed width_code is the smaller of local_width and the neighbour's code, taken from bits 17:16 of its mapped frame.
- R5: The rate test starts at rate_sel = 0, the fastest setting. A valid mapped word that differs from the test word within the low 4, 8, 16 or 32 bits of the agreed width is a mismatch. Each mismatch raises rate_sel by exactly one and restarts the check window.
- R6: link_up rises after WINDOW consecutive matching test words at one setting: exactly SETTLE+WINDOW cycles after the rate test begins when no mismatch occurs. After that, every output stays constant until reset.
- R7: A mismatch at the slowest setting (rate_sel = 3) raises train_err, and link_up then stays 0.
- R8: If a waiting state accepts no usable word for TIMEOUT consecutive cycles, leaf is raised. With no neighbour at all, leaf rises on the (TIMEOUT+1)-th rising clock edge after reset is released.
- R9: Received words are ignored for SETTLE cycles after the rate test begins and after each rate step. Frames that are still in flight during the test are neither counted nor treated as mismatches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| local_width | input | 2 | Native width code of this end (0..3 = 4/8/16/32 bits), static |
| rx_lanes | input | 32 | Word received on the link lanes, in pin order |
| rx_valid | input | 1 | A word is present on rx_lanes this cycle |
| tx_lanes | output | 32 | Word transmitted on the link lanes |
| lane_rev | output | 1 | 1 when the neighbour is rotated and lanes are reversed |
| width_code | output | 2 | Agreed width code |
| rate_sel | output | 2 | Divider select, 0 fastest to 3 slowest |
| link_up | output | 1 | Training succeeded |
| train_err | output | 1 | Every divider setting failed |
| leaf | output | 1 | Timed out: port treated as unconnected |

## Verification
A received word is registered first and acts on the state one clock edge later. The bench's neighbour model therefore reacts to tx_lanes at the falling edge, and every result is sampled away from the rising edge. Leaf is checked on both sides of its due edge: it must still be 0 after TIMEOUT edges and must be 1 after TIMEOUT+1. For a clean link, link_up is counted from the first sight of the test word and must come exactly SETTLE+WINDOW edges later. In the width/orientation/rate sweep, the final rate_sel has to equal the bench's first good setting exactly. That requirement catches any stale or in-flight word that was miscounted within the two-cycle loop delay.

// File: rtl/link_train_pkg.sv
// Shared constants, state type and helpers for the link training controller.
// Assumes a 32-lane link mirrored about its centre, with width codes 0..3
// standing for 4, 8, 16 and 32 active data bits.
package link_train_pkg;

    localparam int LANE_COUNT = 32;
    localparam int HALF_LANES = LANE_COUNT / 2;
    localparam int CODE_W     = 2;

    typedef logic [CODE_W-1:0] width_code_t;

    typedef enum logic [2:0] {
        ST_RESET,
        ST_SEND,
        ST_ORIENT,
        ST_WIDTH,
        ST_RATE,
        ST_UP,
        ST_FAIL,
        ST_LEAF
    } train_state_t;

    // Mask of the lanes that carry data at a given width code.
    function automatic logic [LANE_COUNT-1:0] lane_mask(input width_code_t code);
        case (code)
            2'd0:    return LANE_COUNT'(32'h0000_000F);
            2'd1:    return LANE_COUNT'(32'h0000_00FF);
            2'd2:    return LANE_COUNT'(32'h0000_FFFF);
            default: return {LANE_COUNT{1'b1}};
        endcase
    endfunction

    // Narrower of two width codes.
    function automatic width_code_t width_min(input width_code_t a, input width_code_t b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/lt_lane_map.sv
// Lane mapper: passes a word straight through, or swaps lane i with lane
// W-1-i when rev is set, which undoes a neighbour mounted 180 degrees.
// Purely combinational.
module lt_lane_map #(
    parameter int W = 32
) (
    input  logic         rev,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    // One mux per lane, chosen between the same lane and its mirror.
    for (genvar i = 0; i < W; i++) begin : g_lane
        assign dout[i] = rev ? din[W-1-i] : din[i];
    end
endmodule

// File: rtl/lt_timer.sv
// Cycle counter with synchronous clear. It counts while en is high, reports
// at_last when the count sits on LIMIT-1, and wraps to zero from there.
// Assumes LIMIT >= 1.
module lt_timer #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic at_last
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] count_q;

    assign at_last = (count_q == CW'(LIMIT - 1));

    // Count enabled cycles; clear or wrap at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr) begin
            count_q <= '0;
        end else if (en) begin
            count_q <= at_last ? '0 : count_q + CW'(1);
        end
    end

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        count_q < CW'(LIMIT)) else $error("timer beyond limit"); // R8
endmodule

// File: rtl/lt_word_check.sv
// Word classifier for received link words. It detects the training-frame
// shape in pin order and in mirrored order, decodes the peer width code
// from the mapped word, and compares the mapped word with the test word
// over the active lanes. Combinational; assumes a 32-lane link.
module lt_word_check
    import link_train_pkg::*;
#(
    parameter logic [HALF_LANES-1:0] TRAIN_PAT = 16'hA5C3,
    parameter logic [HALF_LANES-1:0] TEST_HI   = 16'h3C5A
) (
    input  logic [LANE_COUNT-1:0] raw_word,
    input  logic [LANE_COUNT-1:0] mapped_word,
    input  width_code_t           width,
    output logic                  seen_norm,
    output logic                  seen_rot,
    output logic                  is_frame,
    output width_code_t           peer_code,
    output logic                  test_ok
);
    localparam logic [LANE_COUNT-1:0] TEST_WORD = {TEST_HI, TRAIN_PAT};

    logic [LANE_COUNT-1:0] flipped;

    // A word has frame shape when it holds the pattern and no stray high bits.
    function automatic logic frame_shape(input logic [LANE_COUNT-1:0] w);
        return (w[HALF_LANES-1:0] == TRAIN_PAT) &&
               (w[LANE_COUNT-1:HALF_LANES+CODE_W] == '0);
    endfunction

    lt_lane_map #(.W(LANE_COUNT)) u_flip (
        .rev  (1'b1),
        .din  (raw_word),
        .dout (flipped)
    );

    // Classify the raw and mapped words.
    always_comb begin
        seen_norm = frame_shape(raw_word);
        seen_rot  = frame_shape(flipped);
        is_frame  = frame_shape(mapped_word);
        peer_code = mapped_word[HALF_LANES+CODE_W-1:HALF_LANES];
        test_ok   = ((mapped_word ^ TEST_WORD) & lane_mask(width)) == '0;
    end

    // Both orientations can never match the same word.
    always_comb begin
        if (!$isunknown(raw_word)) begin
            AST_ORIENT_UNIQUE: assert (!(seen_norm && seen_rot)) else $error("ambiguous orientation"); // R3
        end
    end
endmodule

// File: rtl/link_trainer.sv
// Power-up training controller for a mirrored chip-to-chip link.
// Sequence: reset, wait for any word, detect orientation, exchange width,
// test rates from fastest to slowest, then end in link-up, failure or
// leaf (timeout). Assumes local_width is static and that the neighbour
// runs the same procedure. Inputs are registered once before use.
module link_trainer
    import link_train_pkg::*;
#(
    parameter logic [15:0] TRAIN_PAT = 16'hA5C3,
    parameter logic [15:0] TEST_HI   = 16'h3C5A,
    parameter int          TIMEOUT   = 1024,
    parameter int          WINDOW    = 32,
    parameter int          SETTLE    = 4,
    parameter int          NUM_RATES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  local_width,
    input  logic [31:0] rx_lanes,
    input  logic        rx_valid,
    output logic [31:0] tx_lanes,
    output logic        lane_rev,
    output logic [1:0]  width_code,
    output logic [$clog2(NUM_RATES)-1:0] rate_sel,
    output logic        link_up,
    output logic        train_err,
    output logic        leaf
);
    localparam int RATE_W = $clog2(NUM_RATES);
    localparam int SW     = $clog2(SETTLE + 1);
    localparam logic [RATE_W-1:0] LAST_RATE = RATE_W'(NUM_RATES - 1);

    train_state_t          state_q, state_d;
    logic [LANE_COUNT-1:0] rx_q, rx_mapped;
    logic                  rxv_q;
    logic                  rev_q, rev_d;
    width_code_t           width_q, width_d;
    logic [RATE_W-1:0]     rate_q, rate_d;
    logic [SW-1:0]         settle_q;
    logic                  settled;
    logic                  seen_norm, seen_rot, is_frame, test_ok;
    width_code_t           peer_code;
    logic                  accept, win_ok, win_clr;
    logic                  to_en, to_last, win_last;

    // Register the incoming lanes once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q  <= '0;
            rxv_q <= 1'b0;
        end else begin
            rx_q  <= rx_lanes;
            rxv_q <= rx_valid;
        end
    end

    lt_lane_map #(.W(LANE_COUNT)) u_rx_map (
        .rev  (rev_q),
        .din  (rx_q),
        .dout (rx_mapped)
    );

    lt_word_check #(.TRAIN_PAT(TRAIN_PAT), .TEST_HI(TEST_HI)) u_check (
        .raw_word    (rx_q),
        .mapped_word (rx_mapped),
        .width       (width_q),
        .seen_norm   (seen_norm),
        .seen_rot    (seen_rot),
        .is_frame    (is_frame),
        .peer_code   (peer_code),
        .test_ok     (test_ok)
    );

    assign settled = (settle_q == SW'(SETTLE));
    assign to_en   = (state_q == ST_SEND) || (state_q == ST_ORIENT) ||
                     (state_q == ST_WIDTH) || ((state_q == ST_RATE) && settled);

    lt_timer #(.LIMIT(TIMEOUT)) u_timeout (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     ((state_d != state_q) || accept),
        .en      (to_en),
        .at_last (to_last)
    );

    lt_timer #(.LIMIT(WINDOW)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     ((state_d != state_q) || win_clr),
        .en      (win_ok),
        .at_last (win_last)
    );

    // Next-state and result decisions for the training sequence.
    always_comb begin
        state_d = state_q;
        rev_d   = rev_q;
        width_d = width_q;
        rate_d  = rate_q;
        accept  = 1'b0;
        win_ok  = 1'b0;
        win_clr = 1'b0;
        case (state_q)
            ST_RESET: state_d = ST_SEND;
            ST_SEND: begin
                if (rxv_q) begin
                    accept  = 1'b1;
                    state_d = ST_ORIENT;
                end else if (to_last) begin
                    state_d = ST_LEAF;
                end
            end
            ST_ORIENT: begin
                if (rxv_q && (seen_norm || seen_rot)) begin
                    accept  = 1'b1;
                    rev_d   = seen_rot;
                    state_d = ST_WIDTH;
                end else if (to_last) begin
                    state_d = ST_LEAF;
                end
            end
            ST_WIDTH: begin
                if (rxv_q && is_frame) begin
                    accept  = 1'b1;
                    width_d = width_min(local_width, peer_code);
                    state_d = ST_RATE;
                end else if (to_last) begin
                    state_d = ST_LEAF;
                end
            end
            ST_RATE: begin
                if (!settled) begin
                    state_d = ST_RATE;
                end else if (rxv_q) begin
                    accept = 1'b1;
                    if (is_frame) begin
                        state_d = ST_RATE;
                    end else if (test_ok) begin
                        win_ok = 1'b1;
                        if (win_last) state_d = ST_UP;
                    end else begin
                        win_clr = 1'b1;
                        if (rate_q == LAST_RATE) state_d = ST_FAIL;
                        else                     rate_d  = rate_q + RATE_W'(1);
                    end
                end else if (to_last) begin
                    state_d = ST_LEAF;
                end
            end
            default: state_d = state_q;
        endcase
    end

    // State and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
            rev_q   <= 1'b0;
            width_q <= '0;
            rate_q  <= '0;
        end else begin
            state_q <= state_d;
            rev_q   <= rev_d;
            width_q <= width_d;
            rate_q  <= rate_d;
        end
    end

    // Settling delay after entering the rate test and after each rate step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settle_q <= '0;
        end else if ((state_q != ST_RATE) || (rate_d != rate_q)) begin
            settle_q <= '0;
        end else if (!settled) begin
            settle_q <= settle_q + SW'(1);
        end
    end

    // Transmit the frame while training, and the test word from the rate test on.
    always_comb begin
        if ((state_q == ST_RATE) || (state_q == ST_UP))
            tx_lanes = {TEST_HI, TRAIN_PAT};
        else
            tx_lanes = {{(LANE_COUNT-HALF_LANES-CODE_W){1'b0}}, local_width, TRAIN_PAT};
    end

    assign lane_rev   = rev_q;
    assign width_code = width_q;
    assign rate_sel   = rate_q;
    assign link_up    = (state_q == ST_UP);
    assign train_err  = (state_q == ST_FAIL);
    assign leaf       = (state_q == ST_LEAF);

    AST_RATE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rate_sel) |-> (rate_sel == $past(rate_sel) + RATE_W'(1))) else $error("rate skipped"); // R5
    AST_OUTCOME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up || train_err || leaf) |=> $stable({link_up, train_err, leaf, rate_sel, width_code, lane_rev})) else $error("outcome moved"); // R6
    AST_FAIL_SLOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(train_err) |-> (rate_sel == LAST_RATE)) else $error("failed early"); // R7
    AST_WIDTH_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |-> (width_code <= local_width)) else $error("width too wide"); // R4
endmodule

// File: tb/link_trainer_test.sv
// Bench: a neighbour model drives the link while sweeping widths,
// orientation and the first good rate; expected results are computed here.
module link_trainer_test;
    localparam int TO  = 64;
    localparam int WIN = 8;
    localparam int STL = 4;
    localparam logic [31:0] TWORD = 32'h3C5A_A5C3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  local_width = 2'd0;
    logic [31:0] rx_lanes = '0;
    logic        rx_valid = 1'b0;
    logic [31:0] tx_lanes;
    logic        lane_rev, link_up, train_err, leaf;
    logic [1:0]  width_code, rate_sel;

    int checks = 0, fails = 0;
    bit done = 0;
    bit nb_on = 0, nb_rot = 0, nb_junk = 0;
    logic [1:0] nb_code = 2'd0;
    int nb_good = 0;

    always #2 clk = ~clk;

    link_trainer #(.TIMEOUT(TO), .WINDOW(WIN), .SETTLE(STL)) uut (
        .clk(clk), .rst_n(rst_n), .local_width(local_width),
        .rx_lanes(rx_lanes), .rx_valid(rx_valid), .tx_lanes(tx_lanes),
        .lane_rev(lane_rev), .width_code(width_code), .rate_sel(rate_sel),
        .link_up(link_up), .train_err(train_err), .leaf(leaf));

    function automatic logic [31:0] rev32(input logic [31:0] w);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = w[31-i];
        return r;
    endfunction

    function automatic logic [31:0] frame(input logic [1:0] c);
        return {14'd0, c, 16'hA5C3};
    endfunction

    // Neighbour model: answers the test word once seen, corrupts lane 0 at bad rates.
    always @(negedge clk) begin
        logic [31:0] w;
        if (!nb_on) begin
            rx_valid <= 1'b0;
            rx_lanes <= '0;
        end else begin
            w = (tx_lanes == TWORD) ? TWORD : frame(nb_code);
            if (nb_junk) w = 32'h1234_5678;
            if ((w == TWORD) && (int'(rate_sel) < nb_good)) w[0] = ~w[0];
            rx_valid <= 1'b1;
            rx_lanes <= nb_rot ? rev32(w) : w;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 800; i++) begin
            @(negedge clk);
            if (link_up || train_err || leaf) break;
        end
    endtask

    initial begin
        #(4 * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1, R2: reset state and transmitted frame.
        local_width = 2'd2; nb_on = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 link_up", 32'(link_up), 0);
        check("R1 train_err", 32'(train_err), 0);
        check("R1 leaf", 32'(leaf), 0);
        check("R1 rate_sel", 32'(rate_sel), 0);
        check("R1 width_code", 32'(width_code), 0);
        check("R1 lane_rev", 32'(lane_rev), 0);
        check("R2 frame", tx_lanes, frame(2'd2));

        // R8: unconnected port, leaf exactly on edge TO+1.
        rst_n = 1'b1;
        repeat (TO) @(posedge clk);
        #1 check("R8 leaf early", 32'(leaf), 0);
        check("R1 link_up while waiting", 32'(link_up), 0);
        @(posedge clk);
        #1 check("R8 leaf due", 32'(leaf), 1);

        // R8: neighbour present but sending junk.
        nb_on = 1; nb_junk = 1;
        do_reset(); wait_end();
        check("R8 junk leaf", 32'(leaf), 1);
        check("R8 junk no link", 32'(link_up), 0);
        nb_junk = 0;

        // R6: clean link latency SETTLE+WINDOW from first test word.
        local_width = 2'd3; nb_code = 2'd3; nb_rot = 0; nb_good = 0;
        do_reset();
        begin
            int k;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (tx_lanes == TWORD) break;
            end
            check("R2 test word", tx_lanes, TWORD);
            k = 0;
            while (!link_up && k < 100) begin
                @(negedge clk);
                k++;
            end
            check("R6 latency", 32'(k), 32'(STL + WIN));
            repeat (20) @(negedge clk);
            check("R6 held", 32'(link_up), 1);
        end

        // R7: all settings fail.
        local_width = 2'd1; nb_code = 2'd2; nb_rot = 1; nb_good = 4;
        do_reset(); wait_end();
        check("R7 train_err", 32'(train_err), 1);
        check("R7 no link", 32'(link_up), 0);
        check("R7 slowest", 32'(rate_sel), 3);

        // R3 R4 R5 R9: sweep widths, orientation and first good rate.
        for (int lw = 0; lw < 4; lw++) begin
            for (int nw = 0; nw < 4; nw++) begin
                for (int ro = 0; ro < 2; ro++) begin
                    local_width = 2'(lw); nb_code = 2'(nw); nb_rot = ro[0];
                    nb_good = (lw * 2 + nw + ro) % 5;
                    do_reset(); wait_end();
                    check("R3 lane_rev", 32'(lane_rev), 32'(ro));
                    check("R4 width", 32'(width_code), 32'((lw < nw) ? lw : nw));
                    if (nb_good < 4) begin
                        check("R5 R9 rate", 32'(rate_sel), 32'(nb_good));
                        check("R6 link_up", 32'(link_up), 1);
                    end else begin
                        check("R7 fail", 32'(train_err), 1);
                        check("R7 rate", 32'(rate_sel), 3);
                    end
                end
            end
        end
        finish_run();
    end
endmodule